// File: doc/BRIEF.md
# Compressed Branch Target Unit

This unit resolves control transfers for a 16-bit compressed instruction encoding. Each cycle it may accept one instruction word with the current program counter (which already runs two halfwords ahead of the instruction), the four condition flags, the link register and the value of a register selected by the instruction. One clock later it reports whether the instruction redirects fetch, where fetch goes next, the new link value with a write strobe, and the execution mode to use afterwards.

Four families are handled. Conditional branches test one of fourteen flag conditions. The short unconditional branch always jumps. The long call is split over two consecutive instructions that pass a partial target through the link register. The exchange branch takes its target from a register and picks the execution mode from bit 0 of that target. The fetch stage uses the taken pulse to flush and refill. Words outside these families leave the program counter and link register unchanged.

Top module: `cbr_target_unit`

## Requirements
- R1: While reset is asserted, and until the first accepted word, res_valid, res_taken and res_lr_we are 0.
- R2: res_valid is 1 exactly one clock after a cycle with in_valid high. When res_valid is 0, res_taken and res_lr_we are 0.
- R3: A word with bits 15:12 = 1101 and a condition code in bits 11:8 below 1110 is taken only when its condition holds. res_pc is then in_pc plus the sign-extended bits 7:0 times 2. Otherwise res_pc equals in_pc.
- R4: Condition codes 0 to 13 test, in order: Z, !Z, C, !C, N, !N, V, !V, C&!Z, !C|Z, N==V, N!=V, !Z&(N==V), Z|(N!=V). in_nzcv is {N,Z,C,V} from bit 3 down to bit 0.
- R5: Codes 1110 and 1111 in that group are never taken. They set res_trap to 01 (undefined) and 10 (software interrupt). Every other word gives res_trap 00.
- R6: A word with bits 15:11 = 11100 is taken, with res_pc = in_pc + sign-extended bits 10:0 times 2.
- R7: A word with bits 15:11 = 11110 is not taken. It writes res_lr = in_pc + (sign-extended bits 10:0 shifted left by 12).
- R8: A word with bits 15:11 = 11111 is taken, with res_pc = in_lr + (zero-extended bits 10:0 times 2). It writes res_lr = (in_pc - 2) with bit 0 set.
- R9: A word with bits 15:7 = 010001110 is an exchange branch. It reads register number bits 6:3 (bit 6 selects the high bank). Its target is in_rm_val, or in_pc when the number is 15. The branch is taken, res_narrow equals target bit 0, and res_pc is the target with bit 0 cleared.
- R10: For an exchange through register 15, bit 1 of res_pc is also cleared.
- R11: Any other word is not taken, writes no link, and gives res_pc = in_pc and res_lr = in_lr. For every non-exchange word res_narrow is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_op | input | 16 | Instruction word |
| in_pc | input | 32 | Program counter, two halfwords ahead |
| in_nzcv | input | 4 | Flags {N,Z,C,V} |
| in_lr | input | 32 | Current link register |
| in_rm_val | input | 32 | Value of the register named in bits 6:3 |
| res_valid | output | 1 | Result present |
| res_taken | output | 1 | Fetch must redirect to res_pc |
| res_pc | output | 32 | Next program counter |
| res_lr | output | 32 | Next link register value |
| res_lr_we | output | 1 | Link register write strobe |
| res_narrow | output | 1 | Next mode: 1 compressed, 0 wide |
| res_trap | output | 2 | 00 none, 01 undefined, 10 software interrupt |

## Verification
A wrong decode, condition table entry or offset shift shows up in the first result cycle, one clock after the word is offered. It appears as a wrong taken bit, a wrong target or a missing link strobe. The reference model predicts every field for every word, so such a fault is caught on the next clock. All fourteen conditions are tried under all sixteen flag patterns. Extreme offsets, a split long call, and exchanges through register 15 with bit 1 set exercise the sign extension and alignment paths that random words reach only rarely.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int OP_W = 16;

  typedef enum logic [2:0] {
    K_NONE    = 3'd0,
    K_COND    = 3'd1,
    K_SHORT   = 3'd2,
    K_LONG_HI = 3'd3,
    K_LONG_LO = 3'd4,
    K_XCHG    = 3'd5
  } kind_e;

  typedef enum logic [1:0] {
    TRAP_NONE  = 2'd0,
    TRAP_UNDEF = 2'd1,
    TRAP_SWI   = 2'd2
  } trap_e;
endpackage

// File: rtl/cbt_decode.sv
module cbt_decode
  import cbt_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output kind_e           kind,
  output trap_e           trap
);
  always_comb begin
    kind = K_NONE;
    trap = TRAP_NONE;
    if (op[15:12] == 4'b1101) begin
      if (op[11:9] == 3'b111) trap = op[8] ? TRAP_SWI : TRAP_UNDEF;
      else                    kind = K_COND;
    end else if (op[15:11] == 5'b11100) begin
      kind = K_SHORT;
    end else if (op[15:11] == 5'b11110) begin
      kind = K_LONG_HI;
    end else if (op[15:11] == 5'b11111) begin
      kind = K_LONG_LO;
    end else if (op[15:7] == 9'b010001110) begin
      kind = K_XCHG;
    end
  end
endmodule

// File: rtl/cbt_cond.sv
module cbt_cond (
  input  logic [3:0] code,
  input  logic [3:0] nzcv,
  output logic       pass
);
  logic n, z, c, v;
  assign {n, z, c, v} = nzcv;

  always_comb begin
    unique case (code)
      4'd0:    pass = z;
      4'd1:    pass = !z;
      4'd2:    pass = c;
      4'd3:    pass = !c;
      4'd4:    pass = n;
      4'd5:    pass = !n;
      4'd6:    pass = v;
      4'd7:    pass = !v;
      4'd8:    pass = c && !z;
      4'd9:    pass = !c || z;
      4'd10:   pass = (n == v);
      4'd11:   pass = (n != v);
      4'd12:   pass = !z && (n == v);
      4'd13:   pass = z || (n != v);
      default: pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/cbt_target.sv
module cbt_target
  import cbt_pkg::*;
#(
  parameter int AW = 32
) (
  input  kind_e           kind,
  input  logic [OP_W-1:0] op,
  input  logic            cond_pass,
  input  logic [AW-1:0]   pc,
  input  logic [AW-1:0]   lr,
  input  logic [AW-1:0]   rm_val,
  output logic            taken,
  output logic [AW-1:0]   pc_next,
  output logic            lr_we,
  output logic [AW-1:0]   lr_next,
  output logic            narrow
);
  localparam logic [3:0] PC_REG = 4'hF;
  localparam int         HI_SH  = 12;

  logic [AW-1:0] off_cond, off_short, off_hi, off_lo;
  logic [AW-1:0] x_src, x_mask;
  logic [3:0]    x_reg;

  assign off_cond  = {{(AW-9){op[7]}}, op[7:0], 1'b0};
  assign off_short = {{(AW-12){op[10]}}, op[10:0], 1'b0};
  assign off_hi    = {{(AW-11-HI_SH){op[10]}}, op[10:0], {HI_SH{1'b0}}};
  assign off_lo    = {{(AW-12){1'b0}}, op[10:0], 1'b0};

  assign x_reg  = op[6:3];
  assign x_src  = (x_reg == PC_REG) ? pc : rm_val;
  assign x_mask = (x_reg == PC_REG) ? ~AW'(3) : ~AW'(1);

  always_comb begin
    taken   = 1'b0;
    pc_next = pc;
    lr_we   = 1'b0;
    lr_next = lr;
    narrow  = 1'b1;
    unique case (kind)
      K_COND: if (cond_pass) begin
        taken   = 1'b1;
        pc_next = pc + off_cond;
      end
      K_SHORT: begin
        taken   = 1'b1;
        pc_next = pc + off_short;
      end
      K_LONG_HI: begin
        lr_we   = 1'b1;
        lr_next = pc + off_hi;
      end
      K_LONG_LO: begin
        taken   = 1'b1;
        pc_next = lr + off_lo;
        lr_we   = 1'b1;
        lr_next = (pc - AW'(2)) | AW'(1);
      end
      K_XCHG: begin
        taken   = 1'b1;
        narrow  = x_src[0];
        pc_next = x_src & x_mask;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cbr_target_unit.sv
module cbr_target_unit
  import cbt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [15:0]   in_op,
  input  logic [AW-1:0] in_pc,
  input  logic [3:0]    in_nzcv,
  input  logic [AW-1:0] in_lr,
  input  logic [AW-1:0] in_rm_val,
  output logic          res_valid,
  output logic          res_taken,
  output logic [AW-1:0] res_pc,
  output logic [AW-1:0] res_lr,
  output logic          res_lr_we,
  output logic          res_narrow,
  output logic [1:0]    res_trap
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  kind_e         kind;
  trap_e         trap;
  logic          cond_pass;
  logic          c_taken, c_lr_we, c_narrow;
  logic [AW-1:0] c_pc, c_lr;

  cbt_decode u_decode (.op(in_op), .kind(kind), .trap(trap));

  cbt_cond u_cond (.code(in_op[11:8]), .nzcv(in_nzcv), .pass(cond_pass));

  cbt_target #(.AW(AW)) u_target (
    .kind(kind), .op(in_op), .cond_pass(cond_pass),
    .pc(in_pc), .lr(in_lr), .rm_val(in_rm_val),
    .taken(c_taken), .pc_next(c_pc), .lr_we(c_lr_we),
    .lr_next(c_lr), .narrow(c_narrow)
  );

  // next state
  logic          valid_d, taken_d, lr_we_d;
  always_comb begin
    valid_d = in_valid;
    taken_d = in_valid && c_taken;
    lr_we_d = in_valid && c_lr_we;
  end

  // strobe registers, updated every cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_valid <= 1'b0;
      res_taken <= 1'b0;
      res_lr_we <= 1'b0;
    end else begin
      res_valid <= valid_d;
      res_taken <= taken_d;
      res_lr_we <= lr_we_d;
    end
  end

  // data registers, loaded only when a word is accepted
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_pc     <= '0;
      res_lr     <= '0;
      res_narrow <= 1'b1;
      res_trap   <= TRAP_NONE;
    end else if (in_valid) begin
      res_pc     <= c_pc;
      res_lr     <= c_lr;
      res_narrow <= c_narrow;
      res_trap   <= trap;
    end
  end
endmodule

// File: rtl/cbr_target_unit_chk.sv
module cbr_target_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [15:0]   in_op,
  input logic [AW-1:0] in_pc,
  input logic [AW-1:0] in_rm_val,
  input logic          res_valid,
  input logic          res_taken,
  input logic [AW-1:0] res_pc,
  input logic          res_lr_we,
  input logic          res_narrow,
  input logic [1:0]    res_trap
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!res_valid && !res_taken && !res_lr_we)
        else $error("R1 outputs active in reset");
    end
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_taken && !res_lr_we));

  assert_trap_not_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_trap != 2'b00) |-> !res_taken);

  assert_first_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[15:11] == 5'b11110) |=> (res_lr_we && !res_taken));

  assert_xchg_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[15:7] == 9'b010001110 && in_op[6:3] != 4'hF)
      |=> (res_taken && res_narrow == $past(in_rm_val[0]) && !res_pc[0]));

  assert_xchg_pc_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[15:7] == 9'b010001110 && in_op[6:3] == 4'hF)
      |=> (res_pc[1:0] == 2'b00 && res_pc[AW-1:2] == $past(in_pc[AW-1:2])));
endmodule

bind cbr_target_unit cbr_target_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_op(in_op),
  .in_pc(in_pc), .in_rm_val(in_rm_val), .res_valid(res_valid),
  .res_taken(res_taken), .res_pc(res_pc), .res_lr_we(res_lr_we),
  .res_narrow(res_narrow), .res_trap(res_trap)
);

// File: tb/cbr_target_unit_tb.sv
module cbr_target_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_op;
  logic [31:0] in_pc, in_lr, in_rm_val;
  logic [3:0]  in_nzcv;
  logic        res_valid, res_taken, res_lr_we, res_narrow;
  logic [31:0] res_pc, res_lr;
  logic [1:0]  res_trap;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbr_target_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_pc(in_pc), .in_nzcv(in_nzcv), .in_lr(in_lr), .in_rm_val(in_rm_val),
    .res_valid(res_valid), .res_taken(res_taken), .res_pc(res_pc),
    .res_lr(res_lr), .res_lr_we(res_lr_we), .res_narrow(res_narrow),
    .res_trap(res_trap)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    bit          valid;
    bit          taken;
    bit          lr_we;
    bit          narrow;
    logic [31:0] pc;
    logic [31:0] lr;
    logic [1:0]  trap;
    string       tag;
  } exp_t;

  exp_t pending[$];

  function automatic bit cond_ok(int code, logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (code)
      0: return z;        1: return !z;
      2: return c;        3: return !c;
      4: return n;        5: return !n;
      6: return v;        7: return !v;
      8: return c && !z;  9: return !c || z;
      10: return n == v;  11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      default: return 0;
    endcase
  endfunction

  function automatic exp_t model(logic [15:0] op, logic [31:0] pc, logic [3:0] f,
                                 logic [31:0] lr, logic [31:0] rv);
    exp_t e;
    int   off;
    logic [31:0] tgt;
    e.valid = 1; e.taken = 0; e.lr_we = 0; e.narrow = 1;
    e.pc = pc; e.lr = lr; e.trap = 2'b00; e.tag = "R11";
    if (op[15:12] == 4'b1101) begin
      if (op[11:8] == 4'hE)      begin e.trap = 2'b01; e.tag = "R5"; end
      else if (op[11:8] == 4'hF) begin e.trap = 2'b10; e.tag = "R5"; end
      else begin
        e.tag = "R3/R4";
        if (cond_ok(int'(op[11:8]), f)) begin
          off = int'($signed(op[7:0])) * 2;
          e.taken = 1; e.pc = pc + 32'(off);
        end
      end
    end else if (op[15:11] == 5'b11100) begin
      off = int'($signed(op[10:0])) * 2;
      e.taken = 1; e.pc = pc + 32'(off); e.tag = "R6";
    end else if (op[15:11] == 5'b11110) begin
      off = int'($signed(op[10:0])) * 4096;
      e.lr_we = 1; e.lr = pc + 32'(off); e.tag = "R7";
    end else if (op[15:11] == 5'b11111) begin
      e.taken = 1; e.pc = lr + 32'(int'(op[10:0]) * 2);
      e.lr_we = 1; e.lr = (pc - 32'd2) | 32'd1; e.tag = "R8";
    end else if (op[15:7] == 9'b010001110) begin
      tgt = (op[6:3] == 4'hF) ? pc : rv;
      e.taken = 1; e.narrow = tgt[0];
      e.pc = (op[6:3] == 4'hF) ? {tgt[31:2], 2'b00} : {tgt[31:1], 1'b0};
      e.tag = (op[6:3] == 4'hF) ? "R10" : "R9";
    end
    return e;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // compare at the falling edge, one clock after the word was driven
  task automatic compare();
    exp_t e;
    if (pending.size() == 0) return;
    e = pending.pop_front();
    chk(res_valid == e.valid, "R2", "valid", 32'(res_valid), 32'(e.valid));
    if (!e.valid) begin
      chk(!res_taken && !res_lr_we, "R2", "idle strobes",
          {30'd0, res_taken, res_lr_we}, 32'd0);
      return;
    end
    chk(res_taken == e.taken, e.tag, "taken", 32'(res_taken), 32'(e.taken));
    chk(res_pc == e.pc, e.tag, "pc", res_pc, e.pc);
    chk(res_lr_we == e.lr_we, e.tag, "lr_we", 32'(res_lr_we), 32'(e.lr_we));
    chk(res_lr == e.lr, e.tag, "lr", res_lr, e.lr);
    chk(res_narrow == e.narrow, e.tag, "mode", 32'(res_narrow), 32'(e.narrow));
    chk(res_trap == e.trap, (e.trap != 0) ? "R5" : e.tag, "trap",
        32'(res_trap), 32'(e.trap));
  endtask

  task automatic issue(bit v, logic [15:0] op, logic [31:0] pc, logic [3:0] f,
                       logic [31:0] lr, logic [31:0] rv);
    exp_t e;
    @(negedge clk);
    compare();
    in_valid = v; in_op = op; in_pc = pc; in_nzcv = f; in_lr = lr; in_rm_val = rv;
    if (v) e = model(op, pc, f, lr, rv);
    else begin e = '{default: 0}; e.tag = "R2"; end
    pending.push_back(e);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pc;
    rst_n = 0; in_valid = 0; in_op = '0; in_pc = '0; in_nzcv = '0;
    in_lr = '0; in_rm_val = '0;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk(!res_valid && !res_taken && !res_lr_we, "R1", "reset outputs",
        {29'd0, res_valid, res_taken, res_lr_we}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!res_valid && !res_taken && !res_lr_we, "R1", "after release",
        {29'd0, res_valid, res_taken, res_lr_we}, 32'd0);

    // R3 R4 R5: every condition code under every flag pattern
    for (int cc = 0; cc < 16; cc++)
      for (int fl = 0; fl < 16; fl++)
        issue(1, {4'b1101, 4'(cc), 8'(cc * 17 + fl)}, 32'h0000_8000, 4'(fl),
              32'h1234_5670, 32'h0);
    // R3 extreme offsets
    issue(1, 16'hD07F, 32'h0000_1000, 4'b0100, 32'h0, 32'h0);
    issue(1, 16'hD080, 32'h0000_1000, 4'b0100, 32'h0, 32'h0);
    // R6 extreme offsets
    issue(1, 16'hE3FF, 32'h0001_0000, 4'h0, 32'h0, 32'h0);
    issue(1, 16'hE400, 32'h0001_0000, 4'h0, 32'h0, 32'h0);
    // R2: gap cycle
    issue(0, 16'hE000, 32'h0, 4'h0, 32'h0, 32'h0);
    // R7 then R8: long call pair, link fed forward as software would
    issue(1, 16'hF7FF, 32'h0002_0004, 4'h0, 32'hAAAA_AAAA, 32'h0);
    issue(1, 16'hFFFE, 32'h0002_0006, 4'h0, 32'h0002_0004 - 32'h1000, 32'h0);
    issue(1, 16'hF400, 32'h0040_0000, 4'h0, 32'h0, 32'h0);
    // R9: exchange to wide mode, to compressed mode, high register
    issue(1, 16'h4708, 32'h100, 4'h0, 32'h0, 32'h0000_3002);
    issue(1, 16'h4770, 32'h100, 4'h0, 32'h0, 32'h0000_4005);
    // R10: exchange through register 15 with bit 1 set
    issue(1, 16'h4778, 32'h0000_1006, 4'h0, 32'h0, 32'hFFFF_FFFF);
    // R11: neighbours of the recognised patterns
    issue(1, 16'h4780, 32'h200, 4'hF, 32'h55, 32'h77);
    issue(1, 16'h0000, 32'h200, 4'hF, 32'h55, 32'h77);
    issue(1, 16'hC000, 32'h200, 4'hF, 32'h55, 32'h77);
    issue(1, 16'hE800, 32'h200, 4'hF, 32'h55, 32'h77);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] op;
      int sel = $urandom_range(0, 6);
      op = 16'($urandom);
      case (sel)
        0: op[15:12] = 4'b1101;
        1: op[15:11] = 5'b11100;
        2: op[15:11] = 5'b11110;
        3: op[15:11] = 5'b11111;
        4: op[15:7]  = 9'b010001110;
        default: ;
      endcase
      pc = $urandom;
      pc[0] = 1'b0;
      issue(($urandom_range(0, 7) != 0), op, pc, 4'($urandom), $urandom, $urandom);
    end
    issue(0, 16'h0, 32'h0, 4'h0, 32'h0, 32'h0);
    @(negedge clk);
    compare();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule